// File: doc/BRIEF.md
# Secured Fuse-Map Store with User Signature

This block keeps the configuration fuse map of a small programmable logic device, an eight-byte user signature and one lock bit. A programming agent talks to it through a single command channel. The channel carries an operation code, an address and a write word. Every accepted command returns exactly one response word, which holds read data or zero, together with an error flag.

Setting the lock protects the fuse pattern. From then on, verify reads of the fuse map return zero and raise the error flag, and register preload requests are refused. The signature bytes can still be read and written. Only a bulk erase returns the block to its unlocked, blank state.

The command channel uses valid/ready. `cmd_ready` is low for the whole busy window of a program, signature write or erase. A command offered while `cmd_ready` is low is not taken, and the agent must hold or re-offer it. The response and preload outputs cannot be stalled. Each one is a single-cycle pulse, and the agent must capture it in that cycle.

Top module: `cfg_vault`

## Requirements
- R1: After reset `busy`, `locked`, `rsp_valid` and `preload_valid` are 0 and `cmd_ready` is 1. Every fuse word and every signature byte reads 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1, and `cmd_ready` equals the inverse of `busy`. Each accepted command produces one `rsp_valid` pulse in the cycle after acceptance. A command offered while busy has no effect and produces no response.
- R3: Operation code 1 (program) stores `cmd_wdata` in fuse word `cmd_addr`. Operation code 2 (verify) returns that word with `rsp_err` = 0 while unlocked.
- R4: Program (code 1) and signature write (code 3) raise `busy` for exactly PROG_CYC cycles, starting the cycle after acceptance. Erase (code 7) raises it for exactly ERASE_CYC cycles.
- R5: Operation code 3 writes `cmd_wdata[7:0]` to the signature byte selected by `cmd_addr[2:0]`. Operation code 4 returns that byte zero-extended. The eight bytes are independent of one another.
- R6: Operation code 6 (secure) sets `locked` at the edge that accepts it and does not raise `busy`. A verify accepted in the very next cycle is already refused.
- R7: A verify accepted while locked returns `rsp_data` = 0 with `rsp_err` = 1 for that one response.
- R8: Operation code 5 (preload) while unlocked pulses `preload_valid` for one cycle, in the cycle after acceptance, with `preload_data` = `cmd_wdata`, and responds with error 0. While locked it produces no `preload_valid` and responds with error 1.
- R9: Signature reads and writes work unchanged while locked and respond with error 0.
- R10: Erase (code 7) clears every fuse word, every signature byte and the lock bit.
- R11: No command other than erase clears `locked`. Operation code 0 (no-op), and every command other than verify and signature read, responds with data 0 and error 0, except for the refusals in R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (not busy) |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W | Fuse word address; low 3 bits select the signature byte |
| cmd_wdata | input | DATA_W | Write word or preload value |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Read data, or 0 |
| rsp_err | output | 1 | Request refused by the lock |
| busy | output | 1 | Program or erase window in progress |
| locked | output | 1 | Security lock state |
| preload_valid | output | 1 | One-cycle register preload strobe |
| preload_data | output | DATA_W | Value to preload |

## Verification
The bench offers a verify in the cycle right after the secure command. A design that delayed the lock by one cycle would leak the fuse word there. It also offers a signature write while a program is in progress. If that write landed, the byte would change, and an extra response would hit the scoreboard with nothing expected. The busy window is counted cycle by cycle for both program and erase, so an off-by-one in the timer is caught. A program, a preload and a signature write are each issued while locked. These show whether the lock is cleared by anything except erase, whether the signature path is wrongly blocked, and whether preload leaks past the lock.

// File: rtl/cv_pkg.sv
package cv_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PROG    = 3'd1,
    OP_VERIFY  = 3'd2,
    OP_SIG_WR  = 3'd3,
    OP_SIG_RD  = 3'd4,
    OP_PRELOAD = 3'd5,
    OP_SECURE  = 3'd6,
    OP_ERASE   = 3'd7
  } cv_op_e;

  localparam int SIG_BYTES = 8;
  localparam int SIG_IDX_W = 3;
endpackage

// File: rtl/cv_busy_timer.sv
module cv_busy_timer #(
  parameter int MAX_CYC = 12,
  localparam int CNT_W = $clog2(MAX_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= len;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  p_busy_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load && (len != 0) |=> busy);
  p_busy_counts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !load |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/cv_sig_bank.sv
module cv_sig_bank
  import cv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 we,
  input  logic [SIG_IDX_W-1:0] idx,
  input  logic [7:0]           wd,
  output logic [7:0]           rdata
);
  logic [7:0] mem [SIG_BYTES];

  for (genvar g = 0; g < SIG_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                      mem[g] <= '0;
      else if (we && idx == SIG_IDX_W'(g))    mem[g] <= wd;
    end
    p_sig_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> mem[g] == 8'h00);
    p_sig_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we && !clr && idx == SIG_IDX_W'(g) |=> mem[g] == $past(wd));
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/cv_fuse_array.sv
module cv_fuse_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                  mem[g] <= '0;
      else if (we && addr == ADDR_W'(g))  mem[g] <= wd;
    end
    p_fuse_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> mem[g] == '0);
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cfg_vault.sv
module cfg_vault
  import cv_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 5,
  parameter int ERASE_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              busy,
  output logic              locked,
  output logic              preload_valid,
  output logic [DATA_W-1:0] preload_data
);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  cv_op_e            op;
  logic              accept, is_erase, is_write, lock_q;
  logic [DATA_W-1:0] fuse_rd;
  logic [7:0]        sig_rd;
  logic [CNT_W-1:0]  len;

  assign op        = cv_op_e'(cmd_op);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign is_erase  = accept && (op == OP_ERASE);
  assign is_write  = accept && (op == OP_PROG || op == OP_SIG_WR || op == OP_ERASE);
  assign len       = (op == OP_ERASE) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);

  cv_busy_timer #(.MAX_CYC(MAX_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(is_write), .len(len), .busy(busy));

  cv_fuse_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fuse (
    .clk(clk), .rst_n(rst_n), .clr(is_erase),
    .we(accept && op == OP_PROG), .addr(cmd_addr), .wd(cmd_wdata), .rdata(fuse_rd));

  cv_sig_bank i_sig (
    .clk(clk), .rst_n(rst_n), .clr(is_erase),
    .we(accept && op == OP_SIG_WR), .idx(cmd_addr[SIG_IDX_W-1:0]),
    .wd(cmd_wdata[7:0]), .rdata(sig_rd));

  always_ff @(posedge clk) begin
    if (!rst_n)                              lock_q <= 1'b0;
    else if (is_erase)                       lock_q <= 1'b0;
    else if (accept && op == OP_SECURE)      lock_q <= 1'b1;
  end
  assign locked = lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_err       <= 1'b0;
      preload_valid <= 1'b0;
      preload_data  <= '0;
    end else begin
      rsp_valid     <= accept;
      rsp_err       <= accept && lock_q && (op == OP_VERIFY || op == OP_PRELOAD);
      preload_valid <= accept && !lock_q && (op == OP_PRELOAD);
      if (accept && !lock_q && op == OP_PRELOAD) preload_data <= cmd_wdata;
      if (accept && !lock_q && op == OP_VERIFY)  rsp_data <= fuse_rd;
      else if (accept && op == OP_SIG_RD)        rsp_data <= DATA_W'(sig_rd);
      else                                       rsp_data <= '0;
    end
  end

  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rsp_valid);
  p_secure_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_SECURE |=> locked && !busy);
  p_verify_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && lock_q && op == OP_VERIFY |=> rsp_valid && rsp_err && rsp_data == '0);
  p_preload_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && lock_q && op == OP_PRELOAD |=> !preload_valid && rsp_err);
  p_lock_only_erase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !is_erase |=> lock_q);
  p_err_has_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid && rsp_data == '0);
endmodule

// File: tb/test_cfg_vault.sv
`timescale 1ns/1ps
module test_cfg_vault;
  localparam int ADDR_W = 4, DATA_W = 8, PROG_CYC = 5, ERASE_CYC = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic rsp_valid, rsp_err, busy, locked, preload_valid;
  logic [DATA_W-1:0] rsp_data, preload_data;

  int errors = 0, checks = 0, pre_cnt = 0;
  logic [DATA_W-1:0] pre_last = '0;
  bit done = 0;

  logic [DATA_W-1:0] exp_data [$];
  logic              exp_err  [$];
  string             exp_tag  [$];

  always #2 clk = ~clk;

  cfg_vault #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC))
  i_cfg_vault (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard for each response
  always @(negedge clk) begin
    if (rst_n && preload_valid) begin
      pre_cnt++;
      pre_last = preload_data;
    end
    if (rst_n && rsp_valid) begin
      if (exp_data.size() == 0) chk(0, "R2 unexpected response", int'(rsp_data), 0);
      else begin
        logic [DATA_W-1:0] d;
        logic e;
        string t;
        d = exp_data.pop_front();
        e = exp_err.pop_front();
        t = exp_tag.pop_front();
        chk(rsp_data == d, {t, " data"}, int'(rsp_data), int'(d));
        chk(rsp_err == e, {t, " err"}, int'(rsp_err), int'(e));
      end
    end
  end

  // Driver: waits for ready, offers one command, records the expected response
  task automatic send(input logic [2:0] op, input int addr, input int wd,
                      input int ed, input bit ee, input string tag);
    while (!cmd_ready) @(negedge clk);
    exp_data.push_back(DATA_W'(ed));
    exp_err.push_back(ee);
    exp_tag.push_back(tag);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = ADDR_W'(addr);
    cmd_wdata = DATA_W'(wd);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic count_busy(input int exp, input string tag);
    int n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp, tag, n, exp);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && locked == 0, "R1 busy/locked", {busy, locked}, 0);
    chk(rsp_valid == 0 && preload_valid == 0, "R1 strobes", {rsp_valid, preload_valid}, 0);
    chk(cmd_ready == 1, "R1 ready", int'(cmd_ready), 1);
    send(3'd2, 3, 0, 0, 0, "R1 blank fuse");
    send(3'd4, 6, 0, 0, 0, "R1 blank sig");

    // R3/R4 programming and busy window
    send(3'd1, 3, 'hA5, 0, 0, "R3 prog");
    chk(cmd_ready == 0, "R2 ready low while busy", int'(cmd_ready), 0);
    count_busy(PROG_CYC, "R4 program busy length");
    send(3'd1, 15, 'h3C, 0, 0, "R3 prog");
    send(3'd1, 0, 'hFF, 0, 0, "R3 prog");
    send(3'd2, 3, 0, 'hA5, 0, "R3 verify 3");
    send(3'd2, 15, 0, 'h3C, 0, "R3 verify 15");
    send(3'd2, 0, 0, 'hFF, 0, "R3 verify 0");

    // R5 signature bytes
    for (int i = 0; i < 8; i++) send(3'd3, i, 'h10 + i * 17, 0, 0, "R5 sig write");
    count_busy(PROG_CYC, "R4 sig write busy length");
    for (int i = 0; i < 8; i++) send(3'd4, 8 + i, 0, 'h10 + i * 17, 0, "R5 sig read");
    send(3'd0, 1, 'h99, 0, 0, "R11 nop");

    // R8 preload unlocked
    send(3'd5, 0, 'h5A, 0, 0, "R8 preload ok");
    @(negedge clk);
    chk(pre_cnt == 1 && pre_last == 8'h5A, "R8 preload strobe", int'(pre_last), 'h5A);

    // R2 command offered while busy is dropped
    send(3'd1, 1, 'h55, 0, 0, "R2 prog");
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 2; cmd_wdata = 'hEE;
    @(negedge clk);
    cmd_valid = 1'b0;
    send(3'd4, 2, 0, 'h10 + 2 * 17, 0, "R2 busy write ignored");
    send(3'd2, 1, 0, 'h55, 0, "R3 verify 1");

    // R6/R7 lock takes effect at once
    send(3'd6, 0, 0, 0, 0, "R6 secure");
    chk(locked == 1 && busy == 0, "R6 locked no busy", {locked, busy}, 2);
    send(3'd2, 3, 0, 0, 1, "R6 R7 verify refused");
    send(3'd5, 0, 'h33, 0, 1, "R8 preload refused");
    @(negedge clk);
    chk(pre_cnt == 1, "R8 no preload strobe when locked", pre_cnt, 1);

    // R9 signature while locked
    send(3'd4, 7, 0, 'h10 + 7 * 17, 0, "R9 sig read locked");
    send(3'd3, 5, 'h77, 0, 0, "R9 sig write locked");
    send(3'd4, 5, 0, 'h77, 0, "R9 sig readback locked");
    send(3'd1, 4, 'h12, 0, 0, "R11 prog locked");
    send(3'd0, 0, 0, 0, 0, "R11 nop locked");
    chk(locked == 1, "R11 lock held", int'(locked), 1);

    // R10 erase
    send(3'd7, 0, 0, 0, 0, "R10 erase");
    chk(locked == 0, "R10 lock cleared", int'(locked), 0);
    count_busy(ERASE_CYC, "R4 erase busy length");
    send(3'd2, 3, 0, 0, 0, "R10 fuse cleared");
    send(3'd2, 0, 0, 0, 0, "R10 fuse cleared");
    send(3'd4, 5, 0, 0, 0, "R10 sig cleared");

    repeat (4) @(negedge clk);
    chk(exp_data.size() == 0, "R2 missing responses", exp_data.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule